// File: doc/BRIEF.md
# Sectored Cache Tag Controller

This block holds the tags and per-sector state of a direct-mapped cache. Each 128-byte block is split into two 64-byte sectors. A block has one address tag, and each sector has its own valid bit and dirty bit. A client presents one read or write request at a time. The controller looks up the set, classifies the access and runs the memory traffic the access needs. It then returns a one-cycle response that names the class of the access. The data RAM is outside this block; the controller only tracks which sectors the data RAM holds and in what state.

The three classes behave as follows:
- **Hit.** No memory traffic is issued.
- **Sector miss.** The tag matches, so the controller fetches only the missing 64-byte sector. The tag and the other sector are left untouched.
- **Block miss.** The victim block is retired in a fixed order. First, each modified sector of the victim is written back. Next, a back-invalidate is sent to the inclusive lower-level cache for each sector of the victim that is present. Finally, the requested sector is fetched, and the new tag is installed with only that sector valid.

Top module: `sect_tag_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid`, `mem_req_valid` and `binv_valid` are 0, and every set is empty, so the first access to any address is a block miss with no writeback and no back-invalidate.
- R2: An address splits as follows: bit 6 selects the sector, bits 12:7 select one of 64 sets, and bits 31:13 form the tag. Bits 5:0 do not affect the result.
- R3: `resp_kind` is encoded as 0 for a hit, 1 for a sector miss and 2 for a block miss. A hit issues no memory request and no back-invalidate.
- R4: A sector miss issues exactly one fill read (`mem_req_write`=0) for the 64-byte-aligned address of the requested sector. It keeps the tag and leaves the other sector valid.
- R5: A block miss fills only the requested sector. Afterwards the other sector of the new block is invalid, so a later access to it is a sector miss.
- R6: A write sets the dirty bit of the addressed sector only. A sector that was never written is never written back.
- R7: During a block miss, all writebacks (`mem_req_write`=1) complete before any back-invalidate, and every back-invalidate completes before the fill read. `binv_valid` and `mem_req_valid` are never high in the same cycle.
- R8: Evicting a block sends one back-invalidate for each sector of the victim that is valid. Each carries the victim's tag, set and sector, aligned to 64 bytes. A writeback carries the same address for a dirty sector.
- R9: Each accepted request produces exactly one `resp_valid` pulse. `req_ready` is low from the cycle after acceptance until the response has been given, and no memory or back-invalidate request is issued while the controller is idle.
- R10: While `mem_req_valid` or `binv_valid` is high and not yet accepted, the request stays high and its address (and `mem_req_write`) stay unchanged.
- R11: Every address the controller issues has bits 5:0 equal to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Client request present |
| req_ready | output | 1 | Controller can accept a request |
| req_addr | input | 32 | Byte address of the request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| resp_valid | output | 1 | One-cycle response pulse |
| resp_kind | output | 2 | 0 hit, 1 sector miss, 2 block miss |
| mem_req_valid | output | 1 | Memory request (fill or writeback) present |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 for a sector writeback, 0 for a sector fill |
| mem_req_addr | output | 32 | 64-byte-aligned sector address |
| mem_resp_valid | input | 1 | Fill data has arrived |
| binv_valid | output | 1 | Back-invalidate request to the lower cache |
| binv_ready | input | 1 | Lower cache accepts the back-invalidate |
| binv_addr | output | 32 | 64-byte-aligned address of the line to drop |

## Verification
The assertions cover the protocol rules, which can be checked on every cycle:
- a single response for each accepted request,
- `req_ready` falling after acceptance,
- request stability under backpressure,
- writeback and back-invalidate never overlapping,
- address alignment and a legal response code.

The per-sector state can only be shown by the bench's access sequences, because it appears only in later accesses. These cases are:
- a sector miss leaving the sibling sector valid,
- a block miss leaving it invalid,
- dirty marking of only the written sector,
- which victim sectors are written back or invalidated, and their exact addresses.

The same holds for the full writeback, back-invalidate, fill order, which the bench checks from its log of handshakes.

// File: rtl/sect_pkg.sv
// Shared types of the sectored tag controller.
// Assumes: response codes are part of the external contract (R3).
package sect_pkg;
    typedef enum logic [1:0] {
        KIND_HIT   = 2'd0,
        KIND_SMISS = 2'd1,
        KIND_BMISS = 2'd2
    } kind_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_LOOKUP = 3'd1,
        ST_WB     = 3'd2,
        ST_BINV   = 3'd3,
        ST_FREQ   = 3'd4,
        ST_FWAIT  = 3'd5,
        ST_RESP   = 3'd6
    } st_e;
endpackage

// File: rtl/sect_pick.sv
// Lowest-set-bit picker over a sector mask.
// Assumes: N >= 2; idx is meaningless when any is 0.
module sect_pick #(
    parameter int N  = 2,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  mask,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = i[IW-1:0];
        end
    end

    assign any = |mask;
endmodule

// File: rtl/sect_store.sv
// Tag and per-sector valid/dirty storage, one entry per set.
// Assumes: asynchronous read at rd_idx; one full-entry write per cycle.
module sect_store #(
    parameter int SETS    = 64,
    parameter int TAG_W   = 19,
    parameter int SECTORS = 2,
    localparam int IDX_W  = $clog2(SETS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [SECTORS-1:0] rd_val,
    output logic [SECTORS-1:0] rd_dirt,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [SECTORS-1:0] wr_val,
    input  logic [SECTORS-1:0] wr_dirt
);
    logic [TAG_W-1:0] tag_mem [SETS];

    // Tag array: cleared on reset, replaced on every entry write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tag_mem[s] <= '0;
        end else if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_tag = tag_mem[rd_idx];

    for (genvar g = 0; g < SECTORS; g++) begin : g_sector
        logic [SETS-1:0] v_bits;
        logic [SETS-1:0] d_bits;

        // Valid and dirty column of one sector; reset empties every set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_bits <= '0;
                d_bits <= '0;
            end else if (wr_en) begin
                v_bits[wr_idx] <= wr_val[g];
                d_bits[wr_idx] <= wr_dirt[g];
            end
        end

        assign rd_val[g]  = v_bits[rd_idx];
        assign rd_dirt[g] = d_bits[rd_idx];
    end
endmodule

// File: rtl/sect_seq.sv
// Request sequencer: lookup, sector fill, and victim retirement
// (writebacks, then back-invalidates, then fill and tag install).
// Assumes: one request in flight; fill completion is mem_resp_valid.
module sect_seq
    import sect_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SECT_BYTES = 64,
    parameter int SECTORS    = 2,
    parameter int SETS       = 64,
    localparam int OFF_W = $clog2(SECT_BYTES),
    localparam int SEC_W = $clog2(SECTORS),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - SEC_W - OFF_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_write,
    output logic               resp_valid,
    output logic [1:0]         resp_kind,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic               mem_req_write,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_resp_valid,
    output logic               binv_valid,
    input  logic               binv_ready,
    output logic [ADDR_W-1:0]  binv_addr,
    output logic [IDX_W-1:0]   rd_idx,
    input  logic [TAG_W-1:0]   rd_tag,
    input  logic [SECTORS-1:0] rd_val,
    input  logic [SECTORS-1:0] rd_dirt,
    output logic               wr_en,
    output logic [IDX_W-1:0]   wr_idx,
    output logic [TAG_W-1:0]   wr_tag,
    output logic [SECTORS-1:0] wr_val,
    output logic [SECTORS-1:0] wr_dirt
);
    st_e                st_q, st_d;
    kind_e              kind_q, kind_d;
    logic [TAG_W-1:0]   tag_q, vtag_q;
    logic [IDX_W-1:0]   idx_q;
    logic [SEC_W-1:0]   sec_q;
    logic               wr_q;
    logic [SECTORS-1:0] wbm_q, bim_q;
    logic               load_vict;
    logic [SECTORS-1:0] sel_oh;
    logic               tag_hit;
    logic [SEC_W-1:0]   wb_idx, bi_idx;
    logic               wb_any, bi_any;
    logic               unused_low;

    assign unused_low = ^req_addr[OFF_W-1:0];

    sect_pick #(.N(SECTORS)) u_pick_wb (.mask(wbm_q), .idx(wb_idx), .any(wb_any));
    sect_pick #(.N(SECTORS)) u_pick_bi (.mask(bim_q), .idx(bi_idx), .any(bi_any));

    assign sel_oh  = SECTORS'(1) << sec_q;
    assign tag_hit = (|rd_val) && (rd_tag == tag_q);
    assign rd_idx  = idx_q;
    assign wr_idx  = idx_q;

    // Next state, response class and array update for the current step.
    always_comb begin
        st_d      = st_q;
        kind_d    = kind_q;
        load_vict = 1'b0;
        wr_en     = 1'b0;
        wr_tag    = tag_q;
        wr_val    = rd_val;
        wr_dirt   = rd_dirt;
        case (st_q)
            ST_IDLE:   if (req_valid) st_d = ST_LOOKUP;
            ST_LOOKUP: begin
                if (tag_hit && |(rd_val & sel_oh)) begin
                    kind_d  = KIND_HIT;
                    wr_en   = wr_q;
                    wr_dirt = rd_dirt | sel_oh;
                    st_d    = ST_RESP;
                end else if (tag_hit) begin
                    kind_d = KIND_SMISS;
                    st_d   = ST_FREQ;
                end else begin
                    kind_d    = KIND_BMISS;
                    load_vict = 1'b1;
                    st_d      = ST_WB;
                end
            end
            ST_WB:     if (!wb_any) st_d = ST_BINV;
            ST_BINV:   if (!bi_any) st_d = ST_FREQ;
            ST_FREQ:   if (mem_req_ready) st_d = ST_FWAIT;
            ST_FWAIT: begin
                if (mem_resp_valid) begin
                    wr_en = 1'b1;
                    if (kind_q == KIND_BMISS) begin
                        wr_val  = sel_oh;
                        wr_dirt = wr_q ? sel_oh : '0;
                    end else begin
                        wr_val  = rd_val | sel_oh;
                        wr_dirt = rd_dirt | (wr_q ? sel_oh : '0);
                    end
                    st_d = ST_RESP;
                end
            end
            ST_RESP:   st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // State register and latched request fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            kind_q <= KIND_HIT;
            tag_q  <= '0;
            idx_q  <= '0;
            sec_q  <= '0;
            wr_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            kind_q <= kind_d;
            if (st_q == ST_IDLE && req_valid) begin
                tag_q <= req_addr[ADDR_W-1 -: TAG_W];
                idx_q <= req_addr[OFF_W+SEC_W +: IDX_W];
                sec_q <= req_addr[OFF_W +: SEC_W];
                wr_q  <= req_write;
            end
        end
    end

    // Victim masks: captured at lookup, one bit retired per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vtag_q <= '0;
            wbm_q  <= '0;
            bim_q  <= '0;
        end else if (load_vict) begin
            vtag_q <= rd_tag;
            wbm_q  <= rd_val & rd_dirt;
            bim_q  <= rd_val;
        end else begin
            if (st_q == ST_WB && wb_any && mem_req_ready) wbm_q[wb_idx] <= 1'b0;
            if (st_q == ST_BINV && bi_any && binv_ready)  bim_q[bi_idx] <= 1'b0;
        end
    end

    assign req_ready     = (st_q == ST_IDLE);
    assign resp_valid    = (st_q == ST_RESP);
    assign resp_kind     = kind_q;
    assign mem_req_valid = (st_q == ST_WB && wb_any) || (st_q == ST_FREQ);
    assign mem_req_write = (st_q == ST_WB);
    assign mem_req_addr  = (st_q == ST_WB) ? {vtag_q, idx_q, wb_idx, {OFF_W{1'b0}}}
                                           : {tag_q, idx_q, sec_q, {OFF_W{1'b0}}};
    assign binv_valid    = (st_q == ST_BINV) && bi_any;
    assign binv_addr     = {vtag_q, idx_q, bi_idx, {OFF_W{1'b0}}};
endmodule

// File: rtl/sect_tag_ctrl.sv
// Top of the sectored tag controller: sequencer plus state storage.
// Assumes: direct-mapped, SECTORS sectors of SECT_BYTES per block.
module sect_tag_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int SECT_BYTES = 64,
    parameter int SECTORS    = 2,
    parameter int SETS       = 64,
    localparam int OFF_W = $clog2(SECT_BYTES),
    localparam int SEC_W = $clog2(SECTORS),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W - SEC_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_write,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_resp_valid,
    output logic              binv_valid,
    input  logic              binv_ready,
    output logic [ADDR_W-1:0] binv_addr
);
    logic [IDX_W-1:0]   rd_idx, wr_idx;
    logic [TAG_W-1:0]   rd_tag, wr_tag;
    logic [SECTORS-1:0] rd_val, rd_dirt, wr_val, wr_dirt;
    logic               wr_en;

    sect_seq #(
        .ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES), .SECTORS(SECTORS), .SETS(SETS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_kind(resp_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid),
        .binv_valid(binv_valid), .binv_ready(binv_ready), .binv_addr(binv_addr),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_val(rd_val), .rd_dirt(rd_dirt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_val(wr_val), .wr_dirt(wr_dirt)
    );

    sect_store #(
        .SETS(SETS), .TAG_W(TAG_W), .SECTORS(SECTORS)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(rd_idx), .rd_tag(rd_tag), .rd_val(rd_val), .rd_dirt(rd_dirt),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_tag(wr_tag),
        .wr_val(wr_val), .wr_dirt(wr_dirt)
    );
endmodule

// File: rtl/sect_tag_ctrl_chk.sv
// Protocol checker for sect_tag_ctrl, watching its ports only.
// Assumes: attached by the bind at the end of this file.
module sect_tag_ctrl_chk #(
    parameter int ADDR_W     = 32,
    parameter int SECT_BYTES = 64,
    localparam int OFF_W = $clog2(SECT_BYTES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_kind,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_write,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              binv_valid,
    input logic              binv_ready,
    input logic [ADDR_W-1:0] binv_addr
);
    logic pending;

    // Tracks whether an accepted request still owes its response.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pending <= 1'b0;
        else if (req_valid && req_ready) pending <= 1'b1;
        else if (resp_valid)             pending <= 1'b0;
    end

    assert_resp_owed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> pending);
    assert_no_double_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |-> !pending);
    assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    assert_quiet_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || binv_valid) |-> pending);
    assert_kind_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_kind != 2'd3));
    assert_mem_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));
    assert_binv_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (binv_valid && !binv_ready) |=> (binv_valid && $stable(binv_addr)));
    assert_binv_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> !mem_req_valid);
    assert_mem_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[OFF_W-1:0] == '0));
    assert_binv_align_R11: assert property (@(posedge clk) disable iff (!rst_n)
        binv_valid |-> (binv_addr[OFF_W-1:0] == '0));
endmodule

bind sect_tag_ctrl sect_tag_ctrl_chk #(.ADDR_W(ADDR_W), .SECT_BYTES(SECT_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_kind(resp_kind),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .binv_valid(binv_valid), .binv_ready(binv_ready), .binv_addr(binv_addr)
);

// File: tb/sect_tag_ctrl_test.sv
`timescale 1ns/1ps
module sect_tag_ctrl_test;
    localparam int PERIOD = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        resp_valid;
    logic [1:0]  resp_kind;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_write;
    logic [31:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic        binv_valid;
    logic        binv_ready = 1'b0;
    logic [31:0] binv_addr;

    int checks = 0;
    int fails  = 0;

    always #(PERIOD/2) clk = ~clk;

    sect_tag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .resp_valid(resp_valid), .resp_kind(resp_kind),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_resp_valid(mem_resp_valid),
        .binv_valid(binv_valid), .binv_ready(binv_ready), .binv_addr(binv_addr)
    );

    function automatic logic [31:0] mk(input int tag, input int idx, input int sec);
        return (32'(tag) << 13) | (32'(idx) << 7) | (32'(sec) << 6);
    endfunction

    // Handshake log kept by the memory model: 0 writeback, 1 back-invalidate, 2 fill.
    int          n_wb, n_bi, n_fill, last_kind;
    bit          order_bad;
    logic [31:0] wb_a, bi_a [2], fill_a;
    int          cyc = 0;
    int          fill_cd = 0;

    task automatic clear_log();
        n_wb = 0; n_bi = 0; n_fill = 0; last_kind = 0; order_bad = 0;
        wb_a = '0; bi_a[0] = '0; bi_a[1] = '0; fill_a = '0;
    endtask

    // Memory and lower-cache model: stalls one cycle in three, fills after 3 cycles.
    always @(negedge clk) begin
        cyc++;
        mem_resp_valid = 1'b0;
        if (fill_cd > 0) begin
            if (fill_cd == 1) mem_resp_valid = 1'b1;
            fill_cd--;
        end
        mem_req_ready = (cyc % 3 != 1);
        binv_ready    = (cyc % 3 != 2);
        if (rst_n && mem_req_valid && mem_req_ready) begin
            if (mem_req_write) begin
                if (last_kind > 0) order_bad = 1;
                wb_a = mem_req_addr; n_wb++;
            end else begin
                last_kind = 2; fill_a = mem_req_addr; n_fill++; fill_cd = 3;
            end
        end
        if (rst_n && binv_valid && binv_ready) begin
            if (last_kind > 1) order_bad = 1;
            last_kind = 1;
            if (n_bi < 2) bi_a[n_bi] = binv_addr;
            n_bi++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    int got_kind;

    // Issues one request and waits for its response, checking req_ready stays low (R9).
    task automatic do_op(input logic [31:0] a, input logic w, input string req);
        bit busy_bad = 0;
        bit hung = 1;
        clear_log();
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if (resp_valid) begin hung = 0; break; end
            if (req_ready) busy_bad = 1;
            @(negedge clk);
        end
        got_kind = int'(resp_kind);
        chk(!hung, req, "response seen (R9)", hung, 0);
        chk(!busy_bad, "R9", "req_ready low while busy", busy_bad, 0);
        @(negedge clk);
        chk(!resp_valid && req_ready, "R9", "single response pulse", resp_valid, 0);
    endtask

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  kind;
        logic [1:0]  nwb;
        logic [1:0]  nbi;
    } vec_t;

    // Kinds per R3: 0 hit, 1 sector miss, 2 block miss.
    localparam vec_t VEC [13] = '{
        '{mk(5,3,0),          1'b0, 2'd2, 2'd0, 2'd0}, // R1/R5 cold block miss
        '{mk(5,3,0),          1'b0, 2'd0, 2'd0, 2'd0}, // R3 hit
        '{mk(5,3,1),          1'b0, 2'd1, 2'd0, 2'd0}, // R4 sector miss
        '{mk(5,3,0),          1'b0, 2'd0, 2'd0, 2'd0}, // R4 sibling still valid
        '{mk(5,3,1),          1'b1, 2'd0, 2'd0, 2'd0}, // R6 write hit on sector 1
        '{mk(9,3,0),          1'b0, 2'd2, 2'd1, 2'd2}, // R6/R8 evict: one wb, two binv
        '{mk(9,3,1),          1'b0, 2'd1, 2'd0, 2'd0}, // R5 other sector invalid
        '{mk(9,3,0),          1'b1, 2'd0, 2'd0, 2'd0}, // R6 write hit sector 0
        '{mk(5,3,1),          1'b1, 2'd2, 2'd1, 2'd2}, // R7/R8 evict dirty sector 0
        '{mk(5,3,0),          1'b0, 2'd1, 2'd0, 2'd0}, // R5 sector miss after block miss
        '{mk(7,4,0),          1'b1, 2'd2, 2'd0, 2'd0}, // R2 other set untouched
        '{mk(5,3,0) | 32'h2C, 1'b0, 2'd0, 2'd0, 2'd0}, // R2 low offset bits ignored
        '{mk(7,4,0),          1'b0, 2'd0, 2'd0, 2'd0}  // R2 set 4 still holds tag 7
    };

    initial begin
        clear_log();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(!resp_valid && !mem_req_valid && !binv_valid, "R1", "outputs idle after reset",
            {resp_valid, mem_req_valid, binv_valid}, 0);

        for (int v = 0; v < 13; v++) begin
            do_op(VEC[v].addr, VEC[v].wr, "R3");
            chk(got_kind == int'(VEC[v].kind), "R3", $sformatf("kind vec %0d", v),
                got_kind, VEC[v].kind);
            chk(n_wb == int'(VEC[v].nwb), "R6", $sformatf("writebacks vec %0d", v),
                n_wb, VEC[v].nwb);
            chk(n_bi == int'(VEC[v].nbi), "R8", $sformatf("back-invalidates vec %0d", v),
                n_bi, VEC[v].nbi);
            chk(n_fill == ((VEC[v].kind == 2'd0) ? 0 : 1), "R4",
                $sformatf("fills vec %0d", v), n_fill, (VEC[v].kind == 2'd0) ? 0 : 1);
            if (VEC[v].kind != 2'd0)
                chk(fill_a == (VEC[v].addr & ~32'h3F), "R11",
                    $sformatf("fill address vec %0d", v), fill_a, VEC[v].addr & ~32'h3F);
            chk(!order_bad, "R7", $sformatf("wb/binv/fill order vec %0d", v), order_bad, 0);
        end

        // R8: victim tag 7 set 4 holds only sector 0, dirty (written by vector 10).
        do_op(mk(1,4,1), 1'b0, "R8");
        chk(got_kind == 2, "R5", "block miss on new tag", got_kind, 2);
        chk(n_wb == 1 && wb_a == mk(7,4,0), "R8", "writeback address", wb_a, mk(7,4,0));
        chk(n_bi == 1 && bi_a[0] == mk(7,4,0), "R8", "back-invalidate address",
            bi_a[0], mk(7,4,0));
        chk(fill_a == mk(1,4,1), "R4", "fill sector address", fill_a, mk(1,4,1));
        chk(!order_bad, "R7", "order on eviction", order_bad, 0);

        // R6: clean eviction of a never-written block sends no writeback.
        do_op(mk(2,4,0), 1'b0, "R6");
        chk(n_wb == 0 && n_bi == 1 && bi_a[0] == mk(1,4,1), "R6",
            "clean victim: no writeback, binv of sector 1", n_wb, 0);

        // R1: reset empties the array; a resident block misses again.
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "req_ready after second reset", req_ready, 1);
        do_op(mk(9,3,0), 1'b0, "R1");
        chk(got_kind == 2 && n_wb == 0 && n_bi == 0, "R1",
            "block miss with empty victim after reset", got_kind, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    // Watchdog: ends a hung run as a failure.
    initial begin
        #(PERIOD * 50000);
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule